// File: doc/BRIEF.md
# Terminal Soft Reset Sequencer

This block runs the selective, software-initiated reset of a 1553 remote terminal's control state. The reset can come from two places. The host can request it with a one-cycle strobe when it writes the soft-reset control bit. A received reset-terminal mode command can also start it, but only while the host has set the option bit that allows this.

Once started, the sequence does the following:
- It forces the terminal's status pins low and stops command execution.
- It clears the bus codec state.
- It issues load strobes that put the descriptor base, status-bit, time-tag, test and built-in-test registers back to their reset values. The host configuration is left as it was.
- It walks all descriptor control words in RAM, one read-modify-write per entry, clearing only four flag bits in each.
- When the walk is done, it raises the ready output. Execution resumes only if the host's run-enable bit is set.

The sequencer sits between the host register block, the terminal's command engine and the descriptor RAM. It owns no configuration storage of its own. Its busy output is what the host reads back as the soft-reset bit, and that bit clears itself when the sequence ends.

Top module: `term_soft_reset`

## Requirements
- R1: After reset `rdy` is 1, `busy` is 0, and `mem_en`, `mem_we` and every load strobe are 0. While idle the RAM port is never enabled.
- R2: A `host_srst` pulse seen while idle makes `busy` 1 and `rdy` 0 from the next cycle. While `busy` is 1, `active_o`, `msg_irq_o` and `hw_irq_o` are 0 whatever their core inputs are.
- R3: In the first busy cycle, `codec_clr` and `regs_clr` are 1 for exactly one cycle.
- R4: In that same cycle `dbase_ld` is 1 and `dbase_val` is 0x0200.
- R5: In that same cycle `bitw_ld` is 1 and `bitw_val` equals `bitw_cur` with every bit cleared except bit 5 (the self-test-failed flag), which is kept.
- R6: Entry i (0..127) of the control-word table is at RAM address 0x0200 + 4·i. Each entry is read once, then written once in the next cycle with the value read AND NOT 0x00F0, so bits 7:4 are cleared and all other bits are kept. Entries are visited in ascending order.
- R7: RAM read data is used one cycle after the read is issued. `busy` stays 1 for exactly 257 cycles (1 + 2·128), after which `rdy` returns to 1.
- R8: `exec_o` equals `run_en` while idle and is 0 while busy, so execution resumes after the sweep only if the run-enable bit is set.
- R9: A `rt_reset_cmd` pulse starts the sequence only when `cmd_rst_en` is 1. With `cmd_rst_en` at 0 it has no effect.
- R10: Any trigger seen while `busy` is 1 is ignored: the sweep is neither restarted nor lengthened, and it still writes exactly 128 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_srst | input | 1 | One-cycle strobe: host wrote the soft-reset bit |
| rt_reset_cmd | input | 1 | One-cycle strobe: valid reset-terminal mode command received |
| cmd_rst_en | input | 1 | Host option bit that lets the mode command trigger the reset |
| run_en | input | 1 | Host run-enable (execution) bit |
| core_active | input | 1 | Active status from the command engine |
| core_msg_irq | input | 1 | Message interrupt request from the core |
| core_hw_irq | input | 1 | Hardware interrupt request from the core |
| bitw_cur | input | 16 | Current built-in-test word |
| mem_rdata | input | 16 | Descriptor RAM read data, one cycle after the read |
| rdy | output | 1 | Terminal ready pin |
| busy | output | 1 | Soft reset in progress (read back as the reset bit) |
| active_o | output | 1 | Gated active pin |
| msg_irq_o | output | 1 | Gated message interrupt pin |
| hw_irq_o | output | 1 | Gated hardware interrupt pin |
| exec_o | output | 1 | Command execution enable to the terminal engine |
| codec_clr | output | 1 | One-cycle clear of the bus decoders and encoder |
| regs_clr | output | 1 | One-cycle clear of status-bit, time-tag and test registers |
| dbase_ld | output | 1 | Load strobe for the descriptor base register |
| dbase_val | output | 16 | Value for the descriptor base register |
| bitw_ld | output | 1 | Load strobe for the built-in-test word |
| bitw_val | output | 16 | Value for the built-in-test word |
| mem_en | output | 1 | Descriptor RAM access enable |
| mem_we | output | 1 | Descriptor RAM write enable |
| mem_addr | output | 15 | Descriptor RAM word address |
| mem_wdata | output | 16 | Descriptor RAM write data |

## Verification
The hardest case to reach from the ports is a second trigger that arrives in the middle of the sweep. The engine has no visible index, so a restart would only show up as extra writes or a longer busy window. The bench pulses both trigger sources deep inside a running sweep. It then confirms that the scoreboard received exactly 128 writes, in order, with the masked data expected from its own copy of the RAM, and that `busy` lasted exactly 257 cycles. The bench also fills the RAM model with distinct, mixed patterns, so that a wrong mask, a stale read or an address slip shows up in at least one of the 128 entries.

// File: rtl/term_srst_pkg.sv
// Package: shared types and defaults for the terminal soft reset sequencer.
// Assumes: a single clock domain and a synchronous active-low reset.
package term_srst_pkg;

    typedef enum logic [1:0] {
        SR_IDLE = 2'd0,
        SR_INIT = 2'd1,
        SR_RD   = 2'd2,
        SR_WR   = 2'd3
    } srst_state_t;

    localparam int unsigned DATA_W_DEF  = 16;
    localparam int unsigned ADDR_W_DEF  = 15;
    localparam int unsigned ENTRIES_DEF = 128;

endpackage

// File: rtl/term_srst_trig.sv
// Module: trigger qualification.
// Combines the host strobe with the mode-command strobe (gated by its option
// bit) and accepts a start only while the sequencer is idle.
// Assumes: both strobes are one cycle wide and synchronous to clk.
module term_srst_trig (
    input  logic idle,
    input  logic host_srst,
    input  logic rt_reset_cmd,
    input  logic cmd_rst_en,
    output logic start
);

    // Start request: any enabled source, accepted only while idle.
    always_comb begin
        start = idle & (host_srst | (rt_reset_cmd & cmd_rst_en));
    end

endmodule

// File: rtl/term_srst_ctl.sv
// Module: sequencer state machine and descriptor index.
// One init cycle, then a read cycle and a write cycle per table entry.
// Assumes: RAM read data is valid in the cycle after the read is issued.
module term_srst_ctl
    import term_srst_pkg::*;
#(
    parameter int unsigned ENTRIES = ENTRIES_DEF,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output srst_state_t      state,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    // State and index update; the index advances after each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SR_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                SR_IDLE: begin
                    if (start) begin
                        state <= SR_INIT;
                        idx   <= '0;
                    end
                end
                SR_INIT: state <= SR_RD;
                SR_RD:   state <= SR_WR;
                SR_WR: begin
                    if (idx == LAST_IDX) begin
                        state <= SR_IDLE;
                    end else begin
                        state <= SR_RD;
                        idx   <= idx + 1'b1;
                    end
                end
                default: state <= SR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/term_srst_port.sv
// Module: descriptor RAM port driver.
// Forms the control-word address from the index and writes back the read
// data with the flag mask cleared.
// Assumes: word-addressed RAM, control words spaced 2**STRIDE_LOG2 apart.
module term_srst_port
    import term_srst_pkg::*;
#(
    parameter int unsigned  DATA_W      = DATA_W_DEF,
    parameter int unsigned  ADDR_W      = ADDR_W_DEF,
    parameter int unsigned  IDX_W       = 7,
    parameter int unsigned  STRIDE_LOG2 = 2,
    parameter logic [31:0]  TABLE_BASE  = 32'h0000_0200,
    parameter logic [31:0]  FLAG_MASK   = 32'h0000_00F0
) (
    input  srst_state_t       state,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam logic [ADDR_W-1:0] BASE_A = TABLE_BASE[ADDR_W-1:0];
    localparam logic [DATA_W-1:0] MASK_D = FLAG_MASK[DATA_W-1:0];

    // Access control: read in SR_RD, write in SR_WR, quiet otherwise.
    always_comb begin
        mem_en    = (state == SR_RD) || (state == SR_WR);
        mem_we    = (state == SR_WR);
        mem_addr  = BASE_A + (ADDR_W'(idx) << STRIDE_LOG2);
        mem_wdata = mem_rdata & ~MASK_D;
    end

endmodule

// File: rtl/term_srst_pins.sv
// Module: pin gating and register reload strobes.
// Holds the status pins low during reset, drives ready and execution enable,
// and pulses the reload strobes during the init cycle.
// Assumes: register blocks take the load strobes as synchronous write enables.
module term_srst_pins
    import term_srst_pkg::*;
#(
    parameter int unsigned DATA_W    = DATA_W_DEF,
    parameter int unsigned KEEP_BIT  = 5,
    parameter logic [31:0] DBASE_RST = 32'h0000_0200
) (
    input  srst_state_t       state,
    input  logic              run_en,
    input  logic              core_active,
    input  logic              core_msg_irq,
    input  logic              core_hw_irq,
    input  logic [DATA_W-1:0] bitw_cur,
    output logic              rdy,
    output logic              busy,
    output logic              active_o,
    output logic              msg_irq_o,
    output logic              hw_irq_o,
    output logic              exec_o,
    output logic              codec_clr,
    output logic              regs_clr,
    output logic              dbase_ld,
    output logic [DATA_W-1:0] dbase_val,
    output logic              bitw_ld,
    output logic [DATA_W-1:0] bitw_val
);

    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << KEEP_BIT;

    // Pin gating: status pins and execution are forced low while busy.
    always_comb begin
        busy      = (state != SR_IDLE);
        rdy       = !busy;
        active_o  = core_active  & !busy;
        msg_irq_o = core_msg_irq & !busy;
        hw_irq_o  = core_hw_irq  & !busy;
        exec_o    = run_en & !busy;
    end

    // Reload strobes: all fire together in the single init cycle.
    always_comb begin
        codec_clr = (state == SR_INIT);
        regs_clr  = (state == SR_INIT);
        dbase_ld  = (state == SR_INIT);
        bitw_ld   = (state == SR_INIT);
        dbase_val = DBASE_RST[DATA_W-1:0];
        bitw_val  = bitw_cur & KEEP_MASK;
    end

endmodule

// File: rtl/term_soft_reset.sv
// Module: top of the terminal soft reset sequencer.
// Qualifies triggers, runs the init cycle, sweeps the descriptor control
// words and gates the terminal pins until the sweep is complete.
// Assumes: single-port descriptor RAM with a one-cycle read latency.
module term_soft_reset
    import term_srst_pkg::*;
#(
    parameter int unsigned DATA_W      = DATA_W_DEF,
    parameter int unsigned ADDR_W      = ADDR_W_DEF,
    parameter int unsigned ENTRIES     = ENTRIES_DEF,
    parameter int unsigned STRIDE_LOG2 = 2,
    parameter logic [31:0] TABLE_BASE  = 32'h0000_0200,
    parameter logic [31:0] FLAG_MASK   = 32'h0000_00F0,
    parameter int unsigned KEEP_BIT    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_srst,
    input  logic              rt_reset_cmd,
    input  logic              cmd_rst_en,
    input  logic              run_en,
    input  logic              core_active,
    input  logic              core_msg_irq,
    input  logic              core_hw_irq,
    input  logic [DATA_W-1:0] bitw_cur,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rdy,
    output logic              busy,
    output logic              active_o,
    output logic              msg_irq_o,
    output logic              hw_irq_o,
    output logic              exec_o,
    output logic              codec_clr,
    output logic              regs_clr,
    output logic              dbase_ld,
    output logic [DATA_W-1:0] dbase_val,
    output logic              bitw_ld,
    output logic [DATA_W-1:0] bitw_val,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    srst_state_t      state;
    logic [IDX_W-1:0] idx;
    logic             start;

    term_srst_trig u_trig (
        .idle         (state == SR_IDLE),
        .host_srst    (host_srst),
        .rt_reset_cmd (rt_reset_cmd),
        .cmd_rst_en   (cmd_rst_en),
        .start        (start)
    );

    term_srst_ctl #(.ENTRIES(ENTRIES)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .state (state),
        .idx   (idx)
    );

    term_srst_port #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W),
        .STRIDE_LOG2 (STRIDE_LOG2),
        .TABLE_BASE  (TABLE_BASE),
        .FLAG_MASK   (FLAG_MASK)
    ) u_port (
        .state     (state),
        .idx       (idx),
        .mem_rdata (mem_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    term_srst_pins #(
        .DATA_W    (DATA_W),
        .KEEP_BIT  (KEEP_BIT),
        .DBASE_RST (TABLE_BASE)
    ) u_pins (
        .state        (state),
        .run_en       (run_en),
        .core_active  (core_active),
        .core_msg_irq (core_msg_irq),
        .core_hw_irq  (core_hw_irq),
        .bitw_cur     (bitw_cur),
        .rdy          (rdy),
        .busy         (busy),
        .active_o     (active_o),
        .msg_irq_o    (msg_irq_o),
        .hw_irq_o     (hw_irq_o),
        .exec_o       (exec_o),
        .codec_clr    (codec_clr),
        .regs_clr     (regs_clr),
        .dbase_ld     (dbase_ld),
        .dbase_val    (dbase_val),
        .bitw_ld      (bitw_ld),
        .bitw_val     (bitw_val)
    );

endmodule

// File: rtl/term_srst_chk.sv
// Module: property checker for term_soft_reset, attached with bind.
// Observes ports only.
module term_srst_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_srst,
    input logic              rt_reset_cmd,
    input logic              cmd_rst_en,
    input logic              rdy,
    input logic              busy,
    input logic              active_o,
    input logic              msg_irq_o,
    input logic              hw_irq_o,
    input logic              exec_o,
    input logic              regs_clr,
    input logic              codec_clr,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);

    // R1: the RAM port stays quiet while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);

    // R2: status pins and ready are low throughout the reset
    a_r2_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!active_o && !msg_irq_o && !hw_irq_o && !rdy));

    // R2: a host strobe while idle makes the block busy in the next cycle
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_srst) |=> busy);

    // R3: the clear strobes last one cycle
    a_r3_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_clr || codec_clr) |=> (!regs_clr && !codec_clr));

    // R6: every write follows a read of the same address
    a_r6_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> ($past(mem_en && !mem_we) && mem_addr == $past(mem_addr)));

    // R7: ready comes back only right after a write
    a_r7_rdy_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(mem_we));

    // R8: execution is off while busy
    a_r8_exec_off: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !exec_o);

    // R9: a mode command without its option bit does not start a reset
    a_r9_cmd_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rt_reset_cmd && !cmd_rst_en && !host_srst) |=> !busy);

endmodule

bind term_soft_reset term_srst_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_srst    (host_srst),
    .rt_reset_cmd (rt_reset_cmd),
    .cmd_rst_en   (cmd_rst_en),
    .rdy          (rdy),
    .busy         (busy),
    .active_o     (active_o),
    .msg_irq_o    (msg_irq_o),
    .hw_irq_o     (hw_irq_o),
    .exec_o       (exec_o),
    .regs_clr     (regs_clr),
    .codec_clr    (codec_clr),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr)
);

// File: tb/term_soft_reset_test.sv
// Scoreboard bench: the driver queues the expected RAM writes for each sweep,
// and a negedge monitor pops and compares them as the design writes.
module term_soft_reset_test;

    localparam int          N     = 128;
    localparam logic [14:0] BASE  = 15'h0200;
    localparam logic [15:0] MASK  = 16'h00F0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_srst = 1'b0, rt_reset_cmd = 1'b0, cmd_rst_en = 1'b0, run_en = 1'b0;
    logic core_active = 1'b1, core_msg_irq = 1'b1, core_hw_irq = 1'b1;
    logic [15:0] bitw_cur = 16'hFFFF;
    logic [15:0] mem_rdata = '0;
    logic rdy, busy, active_o, msg_irq_o, hw_irq_o, exec_o;
    logic codec_clr, regs_clr, dbase_ld, bitw_ld, mem_en, mem_we;
    logic [15:0] dbase_val, bitw_val, mem_wdata;
    logic [14:0] mem_addr;

    int total = 0;
    int bad = 0;
    int nwr = 0;
    int cyc = 0;
    bit finished = 1'b0;
    logic [30:0] exp_q[$];
    logic [15:0] ram [0:N-1];

    always #4 clk = ~clk;   // 125 MHz

    term_soft_reset uut (
        .clk(clk), .rst_n(rst_n), .host_srst(host_srst), .rt_reset_cmd(rt_reset_cmd),
        .cmd_rst_en(cmd_rst_en), .run_en(run_en), .core_active(core_active),
        .core_msg_irq(core_msg_irq), .core_hw_irq(core_hw_irq), .bitw_cur(bitw_cur),
        .mem_rdata(mem_rdata), .rdy(rdy), .busy(busy), .active_o(active_o),
        .msg_irq_o(msg_irq_o), .hw_irq_o(hw_irq_o), .exec_o(exec_o),
        .codec_clr(codec_clr), .regs_clr(regs_clr), .dbase_ld(dbase_ld),
        .dbase_val(dbase_val), .bitw_ld(bitw_ld), .bitw_val(bitw_val),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    function automatic int slot(input logic [14:0] a);
        logic [14:0] off;
        off = a - BASE;
        return int'(off[8:2]);
    endfunction

    // RAM model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[slot(mem_addr)] <= mem_wdata;
            else        mem_rdata <= ram[slot(mem_addr)];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare every RAM write against the scoreboard (R6)
    always @(negedge clk) begin
        if (rst_n && mem_en && mem_we) begin
            logic [30:0] e;
            nwr++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected write", int'(mem_addr), 0);
            end else begin
                e = exp_q.pop_front();
                chk(mem_addr == e[30:16], "R6", "write address", int'(mem_addr), int'(e[30:16]));
                chk(mem_wdata == e[15:0], "R6", "write data", int'(mem_wdata), int'(e[15:0]));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic fill(input int seed);
        for (int i = 0; i < N; i++) ram[i] = 16'(i * 16'h0931 + seed) ^ 16'h5AA5;
    endtask

    // Driver: queue expected writes, fire a trigger, check the init cycle and duration
    task automatic run_sweep(input bit use_cmd, input bit poke_mid);
        int busy_cnt;
        int wr0;
        for (int i = 0; i < N; i++)
            exp_q.push_back({BASE + 15'(i * 4), ram[i] & ~MASK});
        wr0 = nwr;
        @(negedge clk);
        if (use_cmd) begin cmd_rst_en = 1'b1; rt_reset_cmd = 1'b1; end
        else host_srst = 1'b1;
        @(negedge clk);
        host_srst = 1'b0; rt_reset_cmd = 1'b0;
        chk(busy == 1'b1 && rdy == 1'b0, use_cmd ? "R9" : "R2", "busy/rdy after trigger",
            {busy, rdy}, 2'b10);
        chk(!active_o && !msg_irq_o && !hw_irq_o, "R2", "pins gated", {active_o, msg_irq_o, hw_irq_o}, 0);
        chk(codec_clr && regs_clr, "R3", "clear strobes", {codec_clr, regs_clr}, 2'b11);
        chk(dbase_ld && dbase_val == 16'h0200, "R4", "dbase reload", int'(dbase_val), 16'h0200);
        chk(bitw_ld && bitw_val == (bitw_cur & 16'h0020), "R5", "bit word", int'(bitw_val),
            int'(bitw_cur & 16'h0020));
        chk(exec_o == 1'b0, "R8", "exec off while busy", exec_o, 0);
        busy_cnt = 1;
        @(negedge clk);
        chk(!codec_clr && !regs_clr, "R3", "clear strobes one cycle", {codec_clr, regs_clr}, 0);
        while (busy) begin
            busy_cnt++;
            if (poke_mid && busy_cnt == 100) begin
                host_srst = 1'b1; rt_reset_cmd = 1'b1; cmd_rst_en = 1'b1;
            end else begin
                host_srst = 1'b0; rt_reset_cmd = 1'b0;
            end
            @(negedge clk);
        end
        host_srst = 1'b0; rt_reset_cmd = 1'b0; cmd_rst_en = 1'b0;
        chk(busy_cnt == 2 * N + 1, poke_mid ? "R10" : "R7", "busy length", busy_cnt, 2 * N + 1);
        chk(nwr - wr0 == N, poke_mid ? "R10" : "R6", "write count", nwr - wr0, N);
        chk(rdy == 1'b1, "R7", "ready after sweep", rdy, 1);
        chk(exec_o == run_en, "R8", "exec after sweep", exec_o, run_en);
        chk(active_o && msg_irq_o && hw_irq_o, "R2", "pins released", {active_o, msg_irq_o, hw_irq_o}, 3'b111);
    endtask

    initial begin
        fill(16'h1234);
        repeat (3) @(negedge clk);
        chk(rdy == 1'b1 && busy == 1'b0, "R1", "reset state rdy/busy", {rdy, busy}, 2'b10);
        chk(!mem_en && !codec_clr && !regs_clr && !dbase_ld && !bitw_ld, "R1", "reset strobes",
            {mem_en, codec_clr, regs_clr, dbase_ld, bitw_ld}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy == 1'b1 && !mem_en, "R1", "idle after reset", {rdy, mem_en}, 2'b10);

        // host trigger, run enable set: execution resumes
        run_en = 1'b1;
        bitw_cur = 16'hFFFF;
        run_sweep(1'b0, 1'b0);

        // mode command without option bit: ignored
        cmd_rst_en = 1'b0; rt_reset_cmd = 1'b1;
        @(negedge clk);
        rt_reset_cmd = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(!busy && !mem_en && rdy, "R9", "gated command ignored", {busy, mem_en, rdy}, 3'b001);
            @(negedge clk);
        end

        // mode command with option bit, run enable clear, different pattern
        fill(16'hBEEF);
        run_en = 1'b0;
        bitw_cur = 16'h00DF;
        run_sweep(1'b1, 1'b0);

        // retrigger in the middle of a sweep
        fill(16'h0F0F);
        run_en = 1'b1;
        bitw_cur = 16'h8421;
        run_sweep(1'b0, 1'b1);

        chk(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule